// File: doc/BRIEF.md
# SCSI Target Command and Message Byte Decoder

This block sits on the target side of a parallel SCSI bus and takes in, one byte at a time, whatever the initiator sends during the message-out and command phases. It works out when a message or a command descriptor block (CDB) is complete. From a finished message it picks up the logical unit number carried by an IDENTIFY. From a finished CDB it derives the length of the following data phase and the direction of that phase.

The only inputs are a byte strobe, the byte itself and a phase select. When a CDB is complete the block raises a one-cycle completion pulse. In the same cycle it presents the captured CDB, with the latched LUN merged in, along with the CDB length, the transfer length in bytes and the transfer direction. These outputs hold until the next CDB completes. Command execution and media access belong to downstream logic.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: The CDB length comes from opcode bits 7:5: groups 0..7 give 6, 10, 10, 12, 16, 12, 10 and 6 bytes. `cmd_done` pulses for one cycle on the clock edge that takes in the last command byte (`byte_vld`=1, `phase_msg`=0), and `cdb_len` shows the length.
- R2: `cdb` holds the completed CDB with byte k at bits 8k+7:8k. Bytes at or beyond the CDB length read zero. All command outputs (`cdb`, `cdb_len`, `xfer_len`, `xfer_dir`) hold their value until the next completion, and they reset to zero.
- R3: The first message byte sets the message length. 0x00, 0x02..0x1F and 0x80..0xFF are one byte long. 0x20..0x2F are two bytes long. Any other first byte starts an extended message: its total length is the value of the second byte, and 3 is assumed until that byte arrives. `msg_done` pulses on the edge that takes in the final message byte (`phase_msg`=1).
- R4: A completed message whose first byte has bit 7 = 1 and bit 5 = 0 sets `lun_vld` and latches its bits 2:0 on `lun`. Any other message leaves `lun_vld` and `lun` unchanged.
- R5: While `lun_vld` is set, a completing CDB has its byte 1 bits 7:5 replaced by `lun`, and `lun_vld` clears on the same edge.
- R6: Opcode 0x0A transfers byte4 × 512 bytes, where byte4 = 0 means 256 blocks. Opcode 0x2A transfers {byte7, byte8} × 512 bytes.
- R7: Opcode 0x0F transfers 512 bytes, 0x0C transfers 8 bytes and 0x11 transfers 4 bytes.
- R8: Any other opcode transfers byte 4 for a 6-byte CDB, or the big-endian value {byte7, byte8} for a longer CDB.
- R9: Opcodes 0x06 and 0x07 report length 0 and direction none. Opcode 0x04 does the same unless byte 1 bit 4 is set, in which case R8 and R11 apply.
- R10: An outbound command whose computed length is 0 reports direction none.
- R11: `xfer_dir` is 2'b00 for none, 2'b01 for in (target to initiator) and 2'b10 for out. The direction comes from an internal opcode table:
  - in: 0x08, 0x12, 0x28, 0xA8, 0xD8 (and others)
  - out: 0x04, 0x0A, 0x0C, 0x0F, 0x11, 0x2A (and others)
  - none: 0x00, 0x06, 0xE0 (and others)
  
  An opcode missing from the table (for example 0x88) reports none and sets the sticky flag `unk_op`, which only reset clears.
- R12: A byte of the other phase abandons a partly received message or CDB. The next byte of the first phase then starts a new unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Byte strobe, one byte per cycle in which it is high |
| phase_msg | input | 1 | 1 = message-out byte, 0 = command byte |
| byte_data | input | 8 | Received byte |
| msg_done | output | 1 | One-cycle pulse: a message completed |
| lun_vld | output | 1 | An IDENTIFY LUN is latched and pending |
| lun | output | 3 | Latched LUN |
| cmd_done | output | 1 | One-cycle pulse: a CDB completed |
| cdb | output | 128 | Captured CDB, byte 0 in bits 7:0 |
| cdb_len | output | 5 | CDB length in bytes |
| xfer_len | output | 16+BLK_SHIFT | Data phase length in bytes |
| xfer_dir | output | 2 | Data phase direction |
| unk_op | output | 1 | Sticky: an opcode not in the table completed |

## Verification
A wrong byte counter shows up at the ports right away. `cmd_done` or `msg_done` fires at the wrong edge, early or late compared with the byte count the opcode or first message byte implies, and every later unit is then framed from the wrong byte. A stale group length or extended-message length leaves the same mark on the very next unit. A LUN latch that fails to clear shows in byte 1 of the next CDB that follows a non-IDENTIFY message. A wrong length or direction decode shows in the same cycle as the completion pulse, so each vector tells at once which opcode rule is wrong.

// File: rtl/scsi_dec_pkg.sv
// Package: shared constants, encodings and decode functions for the
// SCSI command/message decoder. Assumes the SCSI-2 CDB groups and message
// classes; nothing in here holds state.
package scsi_dec_pkg;

    localparam int CDB_BYTES = 16;                  // largest CDB
    localparam int CNT_W     = $clog2(CDB_BYTES + 1);

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_IN   = 2'b01,
        DIR_OUT  = 2'b10
    } xfer_dir_e;

    typedef enum logic [1:0] {
        MSG_ONE = 2'd0,
        MSG_TWO = 2'd1,
        MSG_EXT = 2'd2
    } msg_kind_e;

    typedef struct packed {
        logic      known;
        xfer_dir_e dir;
    } dir_info_t;

    // CDB length for an opcode group (opcode bits 7:5)
    function automatic logic [CNT_W-1:0] group_cdb_len(input logic [2:0] grp);
        case (grp)
            3'd0, 3'd7:       group_cdb_len = CNT_W'(6);
            3'd1, 3'd2, 3'd6: group_cdb_len = CNT_W'(10);
            3'd3, 3'd5:       group_cdb_len = CNT_W'(12);
            default:          group_cdb_len = CNT_W'(16);
        endcase
    endfunction

    // Message class from its first byte
    function automatic msg_kind_e msg_kind(input logic [7:0] b);
        if (b == 8'h00 || (b >= 8'h02 && b <= 8'h1F) || b[7])
            msg_kind = MSG_ONE;
        else if (b >= 8'h20 && b <= 8'h2F)
            msg_kind = MSG_TWO;
        else
            msg_kind = MSG_EXT;
    endfunction

    // Direction table; unlisted opcodes come back as not known
    function automatic dir_info_t opcode_dir(input logic [7:0] op);
        case (op)
            8'h04, 8'h0A, 8'h0C, 8'h0F, 8'h11, 8'h15, 8'h2A, 8'h55, 8'hAA:
                opcode_dir = '{known: 1'b1, dir: DIR_OUT};
            8'h01, 8'h03, 8'h08, 8'h0E, 8'h12, 8'h1A, 8'h25, 8'h28, 8'h34,
            8'h37, 8'h42, 8'h43, 8'h51, 8'h52, 8'h5A, 8'hA8, 8'hB9, 8'hBD,
            8'hBE, 8'hD8, 8'hD9:
                opcode_dir = '{known: 1'b1, dir: DIR_IN};
            8'h00, 8'h05, 8'h06, 8'h07, 8'h09, 8'h0B, 8'h10, 8'h16, 8'h17,
            8'h19, 8'h1B, 8'h1D, 8'h1E, 8'h2B, 8'h35, 8'h45, 8'h47, 8'h48,
            8'h49, 8'h4B, 8'h4E, 8'hA5, 8'hA9, 8'hBA, 8'hBC, 8'hE0, 8'hE3,
            8'hE4:
                opcode_dir = '{known: 1'b1, dir: DIR_NONE};
            default:
                opcode_dir = '{known: 1'b0, dir: DIR_NONE};
        endcase
    endfunction

endpackage

// File: rtl/scsi_msg_assembler.sv
// Message-out assembler: counts message bytes, decides completion from
// the first byte (and the length byte of an extended message), and
// latches the LUN of an IDENTIFY. Assumes stb and abort are never high
// together (one byte per cycle on one phase).
module scsi_msg_assembler
    import scsi_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic       abort,
    input  logic [7:0] data,
    input  logic       lun_clr,
    output logic       msg_done,
    output logic       lun_vld,
    output logic [2:0] lun
);

    logic [7:0] cnt_q;
    logic [7:0] first_q;
    logic [7:0] ext_len_q;
    logic [7:0] first_w;
    logic [7:0] cnt_n;
    logic [7:0] need_w;
    logic       complete_w;

    // Work out the length needed and whether this byte ends the message
    always_comb begin
        first_w = (cnt_q == 8'd0) ? data : first_q;
        cnt_n   = cnt_q + 8'd1;
        case (msg_kind(first_w))
            MSG_ONE: need_w = 8'd1;
            MSG_TWO: need_w = 8'd2;
            default: begin
                if (cnt_q == 8'd0)      need_w = 8'd3;
                else if (cnt_q == 8'd1) need_w = data;
                else                    need_w = ext_len_q;
            end
        endcase
        complete_w = stb && (cnt_n >= need_w);
    end

    // Byte counter, stored header bytes, completion pulse and LUN latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            first_q   <= '0;
            ext_len_q <= '0;
            msg_done  <= 1'b0;
            lun_vld   <= 1'b0;
            lun       <= '0;
        end else begin
            msg_done <= 1'b0;
            if (lun_clr)
                lun_vld <= 1'b0;
            if (abort) begin
                cnt_q <= '0;
            end else if (stb) begin
                if (cnt_q == 8'd0) first_q   <= data;
                if (cnt_q == 8'd1) ext_len_q <= data;
                if (complete_w) begin
                    cnt_q    <= '0;
                    msg_done <= 1'b1;
                    if (first_w[7] && !first_w[5]) begin
                        lun_vld <= 1'b1;
                        lun     <= first_w[2:0];
                    end
                end else begin
                    cnt_q <= cnt_n;
                end
            end
        end
    end

endmodule

// File: rtl/scsi_cdb_capture.sv
// CDB capture: stores command bytes, takes the CDB length from the
// opcode group, and presents the finished CDB combinationally in the
// cycle of its last byte, with bytes past the end zeroed and the pending
// LUN merged into byte 1. Assumes stb and abort are never high together.
module scsi_cdb_capture
    import scsi_dec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stb,
    input  logic                   abort,
    input  logic [7:0]             data,
    input  logic                   lun_vld,
    input  logic [2:0]             lun,
    output logic                   fin,
    output logic [CDB_BYTES*8-1:0] fin_cdb,
    output logic [CNT_W-1:0]       fin_len
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need_q;
    logic [CNT_W-1:0] need_w;
    logic [CNT_W-1:0] cnt_n;

    // Length from the opcode on byte 0, held afterwards
    always_comb begin
        need_w  = (cnt_q == '0) ? group_cdb_len(data[7:5]) : need_q;
        cnt_n   = cnt_q + CNT_W'(1);
        fin     = stb && (cnt_n >= need_w);
        fin_len = need_w;
    end

    // Byte counter and stored length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (stb) begin
            need_q <= need_w;
            cnt_q  <= fin ? '0 : cnt_n;
        end
    end

    for (genvar i = 0; i < CDB_BYTES; i++) begin : g_byte
        logic [7:0] byte_q;
        logic [7:0] byte_w;

        // Store this byte position when its byte arrives
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (stb && !abort && cnt_q == CNT_W'(i))
                byte_q <= data;
        end

        // Finished value of this byte position
        always_comb begin
            if (CNT_W'(i) < cnt_q)       byte_w = byte_q;
            else if (CNT_W'(i) == cnt_q) byte_w = data;
            else                         byte_w = '0;
            if (i == 1 && lun_vld)
                byte_w[7:5] = lun;
        end

        assign fin_cdb[i*8 +: 8] = byte_w;
    end

endmodule

// File: rtl/scsi_xfer_analyzer.sv
// Transfer analyser: purely combinational. From the opcode and the few
// CDB fields that carry counts, derives the data phase length in bytes
// and its direction. Assumes BLK_SHIFT is the log2 of the block size.
module scsi_xfer_analyzer
    import scsi_dec_pkg::*;
#(
    parameter int BLK_SHIFT = 9,
    localparam int XLEN_W   = 16 + BLK_SHIFT
) (
    input  logic [7:0]        opcode,
    input  logic              fmt_data,
    input  logic [7:0]        cnt_b4,
    input  logic [7:0]        cnt_b7,
    input  logic [7:0]        cnt_b8,
    input  logic [CNT_W-1:0]  cdb_len,
    output logic [XLEN_W-1:0] xfer_len,
    output xfer_dir_e         xfer_dir,
    output logic              known
);

    dir_info_t          info;
    logic [XLEN_W-1:0]  generic_len;
    logic [XLEN_W-1:0]  len_w;
    logic [8:0]         blocks6;
    logic               no_data;

    // Length rules by opcode, then direction with zero-length fold
    always_comb begin
        info        = opcode_dir(opcode);
        known       = info.known;
        generic_len = (cdb_len == CNT_W'(6)) ? XLEN_W'(cnt_b4)
                                             : XLEN_W'({cnt_b7, cnt_b8});
        blocks6     = (cnt_b4 == 8'd0) ? 9'd256 : {1'b0, cnt_b4};
        no_data     = 1'b0;
        case (opcode)
            8'h04: begin
                len_w   = fmt_data ? generic_len : '0;
                no_data = !fmt_data;
            end
            8'h06, 8'h07: begin
                len_w   = '0;
                no_data = 1'b1;
            end
            8'h0A:   len_w = XLEN_W'(blocks6) << BLK_SHIFT;
            8'h2A:   len_w = XLEN_W'({cnt_b7, cnt_b8}) << BLK_SHIFT;
            8'h0F:   len_w = XLEN_W'(1) << BLK_SHIFT;
            8'h0C:   len_w = XLEN_W'(8);
            8'h11:   len_w = XLEN_W'(4);
            default: len_w = generic_len;
        endcase
        xfer_len = len_w;
        if (no_data || (info.dir == DIR_OUT && len_w == '0))
            xfer_dir = DIR_NONE;
        else
            xfer_dir = info.dir;
    end

endmodule

// File: rtl/scsi_cmd_decoder.sv
// Top: splits the byte stream by phase into the message assembler and
// the CDB capture, analyses the finished CDB and registers the command
// outputs, which hold until the next completion. Assumes one byte per
// strobe cycle; no back-pressure exists.
module scsi_cmd_decoder
    import scsi_dec_pkg::*;
#(
    parameter int BLK_SHIFT = 9,
    localparam int XLEN_W   = 16 + BLK_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_vld,
    input  logic                   phase_msg,
    input  logic [7:0]             byte_data,
    output logic                   msg_done,
    output logic                   lun_vld,
    output logic [2:0]             lun,
    output logic                   cmd_done,
    output logic [CDB_BYTES*8-1:0] cdb,
    output logic [CNT_W-1:0]       cdb_len,
    output logic [XLEN_W-1:0]      xfer_len,
    output logic [1:0]             xfer_dir,
    output logic                   unk_op
);

    logic                   msg_stb;
    logic                   cmd_stb;
    logic                   fin;
    logic [CDB_BYTES*8-1:0] fin_cdb;
    logic [CNT_W-1:0]       fin_len;
    logic [XLEN_W-1:0]      an_len;
    xfer_dir_e              an_dir;
    logic                   an_known;

    assign msg_stb = byte_vld &  phase_msg;
    assign cmd_stb = byte_vld & ~phase_msg;

    scsi_msg_assembler u_msg (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (msg_stb),
        .abort    (cmd_stb),
        .data     (byte_data),
        .lun_clr  (fin),
        .msg_done (msg_done),
        .lun_vld  (lun_vld),
        .lun      (lun)
    );

    scsi_cdb_capture u_cdb (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (cmd_stb),
        .abort   (msg_stb),
        .data    (byte_data),
        .lun_vld (lun_vld),
        .lun     (lun),
        .fin     (fin),
        .fin_cdb (fin_cdb),
        .fin_len (fin_len)
    );

    scsi_xfer_analyzer #(.BLK_SHIFT(BLK_SHIFT)) u_xfer (
        .opcode   (fin_cdb[7:0]),
        .fmt_data (fin_cdb[12]),
        .cnt_b4   (fin_cdb[39:32]),
        .cnt_b7   (fin_cdb[63:56]),
        .cnt_b8   (fin_cdb[71:64]),
        .cdb_len  (fin_len),
        .xfer_len (an_len),
        .xfer_dir (an_dir),
        .known    (an_known)
    );

    // Register the command outputs on completion; unknown flag is sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
            cdb      <= '0;
            cdb_len  <= '0;
            xfer_len <= '0;
            xfer_dir <= DIR_NONE;
            unk_op   <= 1'b0;
        end else begin
            cmd_done <= fin;
            if (fin) begin
                cdb      <= fin_cdb;
                cdb_len  <= fin_len;
                xfer_len <= an_len;
                xfer_dir <= an_dir;
                if (!an_known)
                    unk_op <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/scsi_cmd_decoder_chk.sv
// Checker: port-level properties of the decoder, attached by bind.
// Assumes the synchronous active-low reset of the decoder.
module scsi_cmd_decoder_chk #(
    parameter int XLEN_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic              phase_msg,
    input logic              msg_done,
    input logic              lun_vld,
    input logic [2:0]        lun,
    input logic              cmd_done,
    input logic [127:0]      cdb,
    input logic [4:0]        cdb_len,
    input logic [XLEN_W-1:0] xfer_len,
    input logic [1:0]        xfer_dir,
    input logic              unk_op
);

    a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cdb_len == 5'd6 || cdb_len == 5'd10 ||
                      cdb_len == 5'd12 || cdb_len == 5'd16));

    a_r1_done_needs_cmd_byte: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(byte_vld && !phase_msg));

    a_r1_done_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> ($stable(cdb_len) && $stable(xfer_len) && $stable(xfer_dir)));

    a_r3_msg_needs_msg_byte: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |-> $past(byte_vld && phase_msg));

    a_r5_lun_merged: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && $past(lun_vld)) |-> (cdb[15:13] == $past(lun)));

    a_r5_lun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !lun_vld);

    a_r10_out_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_dir == 2'b10) |-> (xfer_len != '0));

    a_r11_dir_code: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_dir != 2'b11);

    a_r11_unk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unk_op |=> unk_op);

endmodule

bind scsi_cmd_decoder scsi_cmd_decoder_chk #(.XLEN_W(XLEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .phase_msg (phase_msg),
    .msg_done  (msg_done),
    .lun_vld   (lun_vld),
    .lun       (lun),
    .cmd_done  (cmd_done),
    .cdb       (cdb),
    .cdb_len   (cdb_len),
    .xfer_len  (xfer_len),
    .xfer_dir  (xfer_dir),
    .unk_op    (unk_op)
);

// File: tb/tb_scsi_cmd_decoder.sv
module tb_scsi_cmd_decoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         byte_vld = 1'b0;
    logic         phase_msg = 1'b0;
    logic [7:0]   byte_data = '0;
    logic         msg_done;
    logic         lun_vld;
    logic [2:0]   lun;
    logic         cmd_done;
    logic [127:0] cdb;
    logic [4:0]   cdb_len;
    logic [24:0]  xfer_len;
    logic [1:0]   xfer_dir;
    logic         unk_op;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    scsi_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .phase_msg(phase_msg),
        .byte_data(byte_data), .msg_done(msg_done), .lun_vld(lun_vld),
        .lun(lun), .cmd_done(cmd_done), .cdb(cdb), .cdb_len(cdb_len),
        .xfer_len(xfer_len), .xfer_dir(xfer_dir), .unk_op(unk_op)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b4;
        logic [7:0]  b7;
        logic [7:0]  b8;
        logic [4:0]  len;
        logic [24:0] xl;
        logic [1:0]  dir;
    } vec_t;

    // dir: 0 none, 1 in, 2 out
    localparam vec_t VECS [16] = '{
        '{8'h08, 8'h00, 8'h10, 8'h00, 8'h00, 5'd6,  25'd16,     2'd1},
        '{8'h0A, 8'h00, 8'h00, 8'h00, 8'h00, 5'd6,  25'd131072, 2'd2},
        '{8'h0A, 8'h00, 8'h03, 8'h00, 8'h00, 5'd6,  25'd1536,   2'd2},
        '{8'h2A, 8'h00, 8'h00, 8'h01, 8'h02, 5'd10, 25'd132096, 2'd2},
        '{8'h2A, 8'h00, 8'h00, 8'h00, 8'h00, 5'd10, 25'd0,      2'd0},
        '{8'h28, 8'h00, 8'h00, 8'h00, 8'h20, 5'd10, 25'd32,     2'd1},
        '{8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 5'd6,  25'd512,    2'd2},
        '{8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 5'd6,  25'd8,      2'd2},
        '{8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 5'd6,  25'd4,      2'd2},
        '{8'h04, 8'h00, 8'h05, 8'h00, 8'h00, 5'd6,  25'd0,      2'd0},
        '{8'h04, 8'h10, 8'h04, 8'h00, 8'h00, 5'd6,  25'd4,      2'd2},
        '{8'h06, 8'h00, 8'h05, 8'h00, 8'h00, 5'd6,  25'd0,      2'd0},
        '{8'h12, 8'h00, 8'h24, 8'h00, 8'h00, 5'd6,  25'd36,     2'd1},
        '{8'hA8, 8'h00, 8'h00, 8'h00, 8'h04, 5'd12, 25'd4,      2'd1},
        '{8'hD8, 8'h00, 8'h00, 8'h00, 8'h10, 5'd10, 25'd16,     2'd1},
        '{8'hE0, 8'h00, 8'h07, 8'h00, 8'h00, 5'd6,  25'd7,      2'd0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic pm, input logic [7:0] b);
        @(negedge clk);
        byte_vld  = 1'b1;
        phase_msg = pm;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic send_cdb(input logic [7:0] op, input logic [7:0] b1,
                            input logic [7:0] b4, input logic [7:0] b7,
                            input logic [7:0] b8, input int n);
        for (int i = 0; i < n; i++) begin
            case (i)
                0:       put(1'b0, op);
                1:       put(1'b0, b1);
                4:       put(1'b0, b4);
                7:       put(1'b0, b7);
                8:       put(1'b0, b8);
                default: put(1'b0, 8'h00);
            endcase
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2)
        chk("R2 reset cmd_done", 128'(cmd_done), 128'd0);
        chk("R2 reset cdb_len", 128'(cdb_len), 128'd0);
        chk("R2 reset xfer_dir", 128'(xfer_dir), 128'd0);
        chk("R4 reset lun_vld", 128'(lun_vld), 128'd0);
        chk("R11 reset unk_op", 128'(unk_op), 128'd0);

        // Table of opcodes (R1 R6 R7 R8 R9 R10 R11)
        for (int v = 0; v < 16; v++) begin
            send_cdb(VECS[v].op, VECS[v].b1, VECS[v].b4, VECS[v].b7, VECS[v].b8,
                     int'(VECS[v].len));
            chk($sformatf("R1 vec%0d done", v), 128'(cmd_done), 128'd1);
            chk($sformatf("R1 vec%0d cdb_len", v), 128'(cdb_len), 128'(VECS[v].len));
            chk($sformatf("R2 vec%0d opcode", v), 128'(cdb[7:0]), 128'(VECS[v].op));
            chk($sformatf("R6 R7 R8 R9 vec%0d xfer_len", v), 128'(xfer_len), 128'(VECS[v].xl));
            chk($sformatf("R10 R11 vec%0d xfer_dir", v), 128'(xfer_dir), 128'(VECS[v].dir));
        end
        chk("R11 known opcodes leave unk_op clear", 128'(unk_op), 128'd0);

        // Outputs hold between completions (R2)
        repeat (3) @(negedge clk);
        chk("R2 hold cmd_done", 128'(cmd_done), 128'd0);
        chk("R2 hold cdb_len", 128'(cdb_len), 128'd6);
        chk("R2 hold xfer_len", 128'(xfer_len), 128'd7);

        // Two-byte message (R3)
        put(1'b1, 8'h21);
        chk("R3 two-byte msg not done after 1", 128'(msg_done), 128'd0);
        put(1'b1, 8'h44);
        chk("R3 two-byte msg done after 2", 128'(msg_done), 128'd1);

        // Extended message of total length 4 (R3)
        put(1'b1, 8'h01);
        put(1'b1, 8'h04);
        chk("R3 ext msg not done after 2", 128'(msg_done), 128'd0);
        put(1'b1, 8'hAA);
        chk("R3 ext msg not done after 3", 128'(msg_done), 128'd0);
        put(1'b1, 8'hBB);
        chk("R3 ext msg done after 4", 128'(msg_done), 128'd1);

        // Non-IDENTIFY one-byte message (R3, R4)
        put(1'b1, 8'hE2);
        chk("R3 one-byte msg done", 128'(msg_done), 128'd1);
        chk("R4 non-identify no lun", 128'(lun_vld), 128'd0);

        // IDENTIFY with LUN 3 (R4)
        put(1'b1, 8'hC3);
        chk("R4 identify lun_vld", 128'(lun_vld), 128'd1);
        chk("R4 identify lun", 128'(lun), 128'd3);

        // LUN merge into byte 1, then cleared (R5)
        send_cdb(8'h08, 8'h05, 8'h02, 8'h00, 8'h00, 6);
        chk("R5 merged byte1", 128'(cdb[15:8]), 128'h65);
        chk("R5 lun cleared", 128'(lun_vld), 128'd0);
        send_cdb(8'h08, 8'h05, 8'h02, 8'h00, 8'h00, 6);
        chk("R5 no merge without lun", 128'(cdb[15:8]), 128'h05);

        // Partial CDB abandoned by a message byte (R12)
        put(1'b0, 8'h08);
        put(1'b0, 8'h00);
        put(1'b0, 8'h00);
        put(1'b1, 8'h00);
        chk("R12 msg after partial cdb done", 128'(msg_done), 128'd1);
        chk("R12 partial cdb not done", 128'(cmd_done), 128'd0);
        send_cdb(8'h12, 8'h00, 8'h08, 8'h00, 8'h00, 6);
        chk("R12 fresh cdb opcode", 128'(cdb[7:0]), 128'h12);
        chk("R12 fresh cdb xfer_len", 128'(xfer_len), 128'd8);

        // Partial extended message abandoned by a command (R12)
        put(1'b1, 8'h01);
        send_cdb(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 6);
        put(1'b1, 8'h80);
        chk("R12 msg restarts after cdb", 128'(msg_done), 128'd1);

        // Unknown 16-byte opcode (R1, R8, R11)
        send_cdb(8'h88, 8'h00, 8'h00, 8'h00, 8'h02, 16);
        chk("R1 group4 len 16", 128'(cdb_len), 128'd16);
        chk("R8 unknown generic len", 128'(xfer_len), 128'd2);
        chk("R11 unknown dir none", 128'(xfer_dir), 128'd0);
        chk("R11 unknown flag", 128'(unk_op), 128'd1);

        // Short CDB after long one: upper bytes zero, flag sticky (R2, R11)
        send_cdb(8'h08, 8'h00, 8'h01, 8'h00, 8'h00, 6);
        chk("R2 bytes past length zero", cdb >> 48, 128'd0);
        chk("R11 unk_op sticky", 128'(unk_op), 128'd1);

        summary();
    end

endmodule